// File: doc/BRIEF.md
# Crosspoint Priority Unit for a Diagonal Crossbar Scheduler

This block sits in front of the grant logic of an NxN input-queued crossbar that uses one virtual output queue for each input/output pair. For every crosspoint it computes a weighted urgency score. The score adds three terms: the service weight of the input line, the service weight of the output line, and the fill level of the matching queue multiplied by a scale factor. The fill level is a percentage from 0 to 100. The scale factor doubles once the queue is completely full, so a queue about to drop cells pulls harder than service class alone would allow.

Crosspoints that share no row and no column form a diagonal. Diagonal g holds every crosspoint (i,j) with (i+j) mod N equal to g. The scores of each diagonal are added together. The diagonal with the largest total is chosen as the starting point for the wavefront grant stage. Equal totals are broken by a rotating pointer. The chosen index is captured once per scheduling slot, on a slot strobe. The grant stage and the queue storage are outside this block.

Top module: `xpp_prioritizer`

## Requirements
- R1: The score of crosspoint (i,j) equals in_qos[i] + out_qos[j] + K*B, where B is the occupancy percentage of that queue. The score is SCORE_W bits wide and does not overflow at the maximum value 255+255+400 = 910. Crosspoint (i,j) sits at slice i*N+j of the flat score and occupancy vectors.
- R2: K is 2 when the occupancy is below 100.
- R3: K is 4 when the occupancy equals 100.
- R4: An occupancy code above 100 (the field is 7 bits) is treated as a full queue: B is 100 and K is 4.
- R5: Diagonal g is the set of crosspoints with (i+j) mod N == g, and its total is the sum of the scores of those crosspoints.
- R6: On a slot strobe, the diagonal with the largest total is chosen. When totals tie, the lowest index at or after the round-robin pointer wins, counting upward with wraparound. After each strobe the pointer moves to (chosen+1) mod N.
- R7: `start_diag` changes only in the cycle after a clock edge at which `slot_tick` is high. In every other cycle it holds.
- R8: After reset, `start_diag` is 0 and the round-robin pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | Scheduling slot strobe |
| in_qos | input | N*QOS_W | Service weight per input line, line i at slice i |
| out_qos | input | N*QOS_W | Service weight per output line, line j at slice j |
| occ_pct | input | N*N*OCC_W | Queue occupancy percentage, crosspoint (i,j) at slice i*N+j |
| xp_score | output | N*N*SCORE_W | Score per crosspoint, same slice order as occ_pct |
| start_diag | output | IDX_W | Registered starting diagonal for the grant stage |

## Verification
Scores are combinational, so an error in a weight, in the clamp or in a slice index shows up on `xp_score` in the same cycle as the stimulus. The bench's model catches it on the next comparison. A wrong diagonal membership or a broken tie rule affects only `start_diag`, and only one cycle after a strobe. A stale round-robin pointer is invisible until totals tie. The bench therefore applies repeated all-equal slots and a directed single-diagonal load, so that these faults appear within one or two slots.

// File: rtl/xpp_pkg.sv
package xpp_pkg;
    localparam int unsigned PCT_FULL = 100;
    localparam int unsigned K_PART   = 2;
    localparam int unsigned K_FULL   = 4;

    function automatic int unsigned score_max(input int unsigned qos_w);
        return 2 * ((1 << qos_w) - 1) + K_FULL * PCT_FULL;
    endfunction
endpackage

// File: rtl/xpp_score.sv
module xpp_score #(
    parameter int unsigned QOS_W    = 8,
    parameter int unsigned OCC_W    = 7,
    parameter int unsigned SCORE_W  = 10,
    parameter int unsigned PCT_FULL = 100,
    parameter int unsigned K_PART   = 2,
    parameter int unsigned K_FULL   = 4
) (
    input  logic [QOS_W-1:0]   qin,
    input  logic [QOS_W-1:0]   qout,
    input  logic [OCC_W-1:0]   occ,
    output logic [SCORE_W-1:0] score
);
    localparam logic [OCC_W-1:0]   FULL_L = OCC_W'(PCT_FULL);
    localparam logic [SCORE_W-1:0] KP     = SCORE_W'(K_PART);
    localparam logic [SCORE_W-1:0] KF     = SCORE_W'(K_FULL);

    logic                full;
    logic [SCORE_W-1:0]  pct;
    logic [SCORE_W-1:0]  weight;

    always_comb begin
        full   = (occ >= FULL_L);
        pct    = full ? SCORE_W'(FULL_L) : SCORE_W'(occ);
        weight = full ? KF : KP;
        score  = SCORE_W'(qin) + SCORE_W'(qout) + weight * pct;
    end
endmodule

// File: rtl/xpp_group_sum.sv
module xpp_group_sum #(
    parameter int unsigned N       = 4,
    parameter int unsigned SCORE_W = 10,
    parameter int unsigned TOT_W   = 12,
    parameter int unsigned GRP     = 0
) (
    input  logic [N*N*SCORE_W-1:0] scores,
    output logic [TOT_W-1:0]       total
);
    logic [SCORE_W-1:0] member [N];

    for (genvar row = 0; row < N; row++) begin : g_member
        localparam int unsigned COL = (GRP + N - row) % N;
        assign member[row] = scores[(row*N + COL)*SCORE_W +: SCORE_W];
    end

    always_comb begin
        total = '0;
        for (int row = 0; row < N; row++) begin
            total = total + TOT_W'(member[row]);
        end
    end
endmodule

// File: rtl/xpp_pick.sv
module xpp_pick #(
    parameter int unsigned N     = 4,
    parameter int unsigned TOT_W = 12,
    parameter int unsigned IDX_W = 2
) (
    input  logic [N*TOT_W-1:0] totals,
    input  logic [IDX_W-1:0]   ptr,
    output logic [IDX_W-1:0]   pick
);
    logic [TOT_W-1:0] best;
    int unsigned      cand;

    always_comb begin
        pick = ptr;
        best = totals[int'(ptr)*TOT_W +: TOT_W];
        cand = 0;
        for (int k = 1; k < N; k++) begin
            cand = int'(ptr) + k;
            if (cand >= N) cand = cand - N;
            if (totals[cand*TOT_W +: TOT_W] > best) begin
                best = totals[cand*TOT_W +: TOT_W];
                pick = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/xpp_prioritizer.sv
module xpp_prioritizer #(
    parameter int unsigned N       = 4,
    parameter int unsigned QOS_W   = 8,
    parameter int unsigned OCC_W   = 7,
    parameter int unsigned SCORE_W = $clog2(xpp_pkg::score_max(QOS_W) + 1),
    parameter int unsigned IDX_W   = (N > 1) ? $clog2(N) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   slot_tick,
    input  logic [N*QOS_W-1:0]     in_qos,
    input  logic [N*QOS_W-1:0]     out_qos,
    input  logic [N*N*OCC_W-1:0]   occ_pct,
    output logic [N*N*SCORE_W-1:0] xp_score,
    output logic [IDX_W-1:0]       start_diag
);
    localparam int unsigned TOT_W = SCORE_W + ((N > 1) ? $clog2(N) : 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [N*TOT_W-1:0] diag_total;
    logic [IDX_W-1:0]   rr_ptr;
    logic [IDX_W-1:0]   pick;
    logic [IDX_W-1:0]   ptr_next;

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            xpp_score #(
                .QOS_W   (QOS_W),
                .OCC_W   (OCC_W),
                .SCORE_W (SCORE_W),
                .PCT_FULL(xpp_pkg::PCT_FULL),
                .K_PART  (xpp_pkg::K_PART),
                .K_FULL  (xpp_pkg::K_FULL)
            ) score_i (
                .qin  (in_qos[r*QOS_W +: QOS_W]),
                .qout (out_qos[c*QOS_W +: QOS_W]),
                .occ  (occ_pct[(r*N + c)*OCC_W +: OCC_W]),
                .score(xp_score[(r*N + c)*SCORE_W +: SCORE_W])
            );
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_diag
        xpp_group_sum #(
            .N      (N),
            .SCORE_W(SCORE_W),
            .TOT_W  (TOT_W),
            .GRP    (g)
        ) sum_i (
            .scores(xp_score),
            .total (diag_total[g*TOT_W +: TOT_W])
        );
    end

    xpp_pick #(
        .N    (N),
        .TOT_W(TOT_W),
        .IDX_W(IDX_W)
    ) pick_i (
        .totals(diag_total),
        .ptr   (rr_ptr),
        .pick  (pick)
    );

    assign ptr_next = (pick == LAST) ? '0 : pick + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_diag <= '0;
            rr_ptr     <= '0;
        end else if (slot_tick) begin
            start_diag <= pick;
            rr_ptr     <= ptr_next;
        end
    end
endmodule

// File: rtl/xpp_prioritizer_chk.sv
module xpp_prioritizer_chk #(
    parameter int unsigned N       = 4,
    parameter int unsigned QOS_W   = 8,
    parameter int unsigned OCC_W   = 7,
    parameter int unsigned SCORE_W = 10,
    parameter int unsigned IDX_W   = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   slot_tick,
    input logic [N*QOS_W-1:0]     in_qos,
    input logic [N*QOS_W-1:0]     out_qos,
    input logic [N*N*OCC_W-1:0]   occ_pct,
    input logic [N*N*SCORE_W-1:0] xp_score,
    input logic [IDX_W-1:0]       start_diag
);
    localparam int MAXS = int'(xpp_pkg::score_max(QOS_W));
    localparam int FULL = int'(xpp_pkg::PCT_FULL);

    int occ0, base0, sc0;
    assign occ0  = int'(occ_pct[OCC_W-1:0]);
    assign base0 = int'(in_qos[QOS_W-1:0]) + int'(out_qos[QOS_W-1:0]);
    assign sc0   = int'(xp_score[SCORE_W-1:0]);

    p_diag_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(start_diag) < N);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> $stable(start_diag));

    p_part_weight_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ0 < FULL) |-> (sc0 == base0 + 2 * occ0));

    p_full_weight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ0 == FULL) |-> (sc0 == base0 + 4 * FULL));

    p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (occ0 > FULL) |-> (sc0 == base0 + 4 * FULL));

    for (genvar x = 0; x < N*N; x++) begin : g_bound
        p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
            int'(xp_score[x*SCORE_W +: SCORE_W]) <= MAXS);
    end
endmodule

bind xpp_prioritizer xpp_prioritizer_chk #(
    .N      (N),
    .QOS_W  (QOS_W),
    .OCC_W  (OCC_W),
    .SCORE_W(SCORE_W),
    .IDX_W  (IDX_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_tick (slot_tick),
    .in_qos    (in_qos),
    .out_qos   (out_qos),
    .occ_pct   (occ_pct),
    .xp_score  (xp_score),
    .start_diag(start_diag)
);

// File: tb/xpp_prioritizer_tb.sv
`timescale 1ns/1ps
module xpp_prioritizer_tb_top;
    localparam int N  = 4;
    localparam int QW = 8;
    localparam int OW = 7;
    localparam int SW = 10;
    localparam int IW = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              slot_tick;
    logic [N*QW-1:0]   in_qos;
    logic [N*QW-1:0]   out_qos;
    logic [N*N*OW-1:0] occ_pct;
    logic [N*N*SW-1:0] xp_score;
    logic [IW-1:0]     start_diag;

    int total_chk = 0;
    int fail_chk  = 0;
    int model_sel = 0;
    int model_ptr = 0;
    bit done      = 1'b0;

    always #2.5 clk = ~clk;

    xpp_prioritizer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_tick (slot_tick),
        .in_qos    (in_qos),
        .out_qos   (out_qos),
        .occ_pct   (occ_pct),
        .xp_score  (xp_score),
        .start_diag(start_diag)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total_chk++;
        if (got != exp) begin
            fail_chk++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int occ_of(input int i, input int j);
        return int'(occ_pct[(i*N + j)*OW +: OW]);
    endfunction

    function automatic int exp_score(input int i, input int j);
        int q = int'(in_qos[i*QW +: QW]) + int'(out_qos[j*QW +: QW]);
        int b = occ_of(i, j);
        if (b >= 100) return q + 400;
        return q + 2 * b;
    endfunction

    function automatic int exp_total(input int g);
        int s = 0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if ((i + j) % N == g) s += exp_score(i, j);
        return s;
    endfunction

    function automatic int exp_pick();
        int best = exp_total(model_ptr);
        int sel  = model_ptr;
        for (int k = 1; k < N; k++) begin
            int g = (model_ptr + k) % N;
            if (exp_total(g) > best) begin
                best = exp_total(g);
                sel  = g;
            end
        end
        return sel;
    endfunction

    task automatic compare_all(input string diag_tag);
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                int b = occ_of(i, j);
                string t = (b < 100) ? "R2" : ((b == 100) ? "R3" : "R4");
                chk(t, int'(xp_score[(i*N + j)*SW +: SW]), exp_score(i, j));
            end
        end
        chk(diag_tag, int'(start_diag), model_sel);
    endtask

    // inputs already set at a falling edge; tick is sampled at the next rising edge
    task automatic step(input bit tick_v, input string tag);
        int p;
        slot_tick = tick_v;
        p = exp_pick();
        @(posedge clk);
        #1;
        if (tick_v) begin
            model_sel = p;
            model_ptr = (p + 1) % N;
        end
        @(negedge clk);
        compare_all(tick_v ? tag : "R7");
    endtask

    task automatic set_all(input int q, input int o);
        for (int i = 0; i < N; i++) begin
            in_qos[i*QW +: QW]  = QW'(q);
            out_qos[i*QW +: QW] = QW'(q);
        end
        for (int x = 0; x < N*N; x++) occ_pct[x*OW +: OW] = OW'(o);
    endtask

    initial begin
        rst_n = 1'b0;
        slot_tick = 1'b0;
        set_all(0, 0);
        repeat (3) @(negedge clk);
        chk("R8", int'(start_diag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", int'(start_diag), 0);

        // equal totals: tie rotates through the pointer
        step(1'b1, "R6");
        chk("R6", int'(start_diag), 0);
        step(1'b1, "R6");
        chk("R6", int'(start_diag), 1);

        // load only diagonal 2
        for (int i = 0; i < N; i++) occ_pct[(i*N + ((2 + N - i) % N))*OW +: OW] = OW'(50);
        step(1'b1, "R5");
        chk("R5", int'(start_diag), 2);

        // favour diagonal 1 without a strobe: output must hold
        set_all(0, 0);
        for (int i = 0; i < N; i++) occ_pct[(i*N + ((1 + N - i) % N))*OW +: OW] = OW'(90);
        step(1'b0, "R7");
        chk("R7", int'(start_diag), 2);
        step(1'b1, "R6");
        chk("R6", int'(start_diag), 1);

        // maximum score
        set_all(255, 100);
        step(1'b1, "R6");
        chk("R1", int'(xp_score[(N*N-1)*SW +: SW]), 910);

        // out-of-range occupancy codes
        set_all(0, 127);
        step(1'b0, "R7");
        chk("R4", int'(xp_score[0 +: SW]), 400);

        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < N; i++) begin
                in_qos[i*QW +: QW]  = QW'($urandom);
                out_qos[i*QW +: QW] = QW'($urandom);
            end
            for (int x = 0; x < N*N; x++) begin
                int r = int'($urandom % 4);
                int v = (r == 0) ? 100 : ((r == 1) ? 100 + int'($urandom % 28) : int'($urandom % 100));
                occ_pct[x*OW +: OW] = OW'(v);
            end
            step(1'($urandom % 2), "R6");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total_chk - fail_chk, total_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total_chk++;
            fail_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total_chk - fail_chk, total_chk);
            $finish;
        end
    end
endmodule